// File: doc/BRIEF.md
# Processor Power State Controller

This block sequences a processor through three power states: run, idle and sleep. Each move between two states takes a fixed latency, counted in clock cycles. The block does not gate any clock or supply. It only keeps track of where the processor is, flags when a move is under way, and reports the nominal power draw for the state the processor currently occupies. The latency depends on the direction of the move. Waking from sleep is by far the slowest move.

Software or a policy unit asks for a lower state with a request pulse. The pulse carries a target (idle or sleep) and a predicted idle duration in cycles. The block accepts the move only when the prediction is strictly above a break-even threshold set for that target, which means the energy saved repays the cost of the move. An interrupt is the only way out of idle. A wake-up event is the only way out of sleep.

Events that arrive while a move is under way are not lost. Interrupts and wake-ups are remembered, and so is the most recent lower-state request. All of them are evaluated in the first free cycle after the block lands in its new state.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset, state_o is run (code 0), busy_o is low and power_uw_o reports the run level.
- R2: power_uw_o is 400000 in run, 50000 in idle (state code 1) and 160 in sleep (state code 2). It always follows the value on state_o.
- R3: In run, a request with target code 0 (idle) and a prediction above BE_IDLE_CYC raises busy_o on the next cycle. busy_o stays high for exactly LAT_RUN_IDLE cycles, and the cycle after that state_o shows idle.
- R4: A request whose prediction is less than or equal to the threshold for its target does not start a move: busy_o stays low and state_o is unchanged.
- R5: From run or from idle, a request with target code 1 (sleep) and a prediction above BE_SLEEP_CYC completes in LAT_TO_SLEEP busy cycles and lands in sleep.
- R6: Idle is left only on irq_i, and the return to run takes LAT_IDLE_RUN busy cycles. wake_i has no effect in idle.
- R7: Sleep is left only on wake_i, and the return to run takes LAT_SLEEP_RUN busy cycles. irq_i and lower-state requests have no effect in sleep.
- R8: In run, irq_i and wake_i have no effect.
- R9: While busy_o is high, state_o and power_uw_o hold the source state. An irq_i, a wake_i or a request that arrives during the move is acted on in the first free cycle after landing, if the new state accepts it.
- R10: In idle, an interrupt takes priority over a lower-state request that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lower_req_i | input | 1 | Request to move to a lower-power state |
| lower_tgt_i | input | 1 | Requested target: 0 idle, 1 sleep |
| pred_idle_i | input | PRED_W | Predicted stay in the target state, in cycles |
| irq_i | input | 1 | Interrupt, leaves idle |
| wake_i | input | 1 | Wake-up event, leaves sleep |
| state_o | output | 2 | Current state: 0 run, 1 idle, 2 sleep |
| busy_o | output | 1 | High while a move is in progress |
| power_uw_o | output | POW_W | Nominal power of the current state, in microwatts |

## Verification
The hardest case to reach is an event that arrives in the middle of a move and is then acted on right after landing. For example, a wake-up pulse can arrive while the block is entering sleep, or an interrupt can arrive while it is entering idle. These events are invisible at the ports until the move completes. The stimulus starts a long move and pulses the event partway through. A behavioural reference model then checks, on every clock, that the follow-up move starts on the first free cycle. Break-even checks use predictions exactly at each threshold and one cycle above it.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SLEEP = 2'd2
  } pstate_e;

  localparam logic TGT_IDLE  = 1'b0;
  localparam logic TGT_SLEEP = 1'b1;
endpackage

// File: rtl/pwr_lat_timer.sv
module pwr_lat_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o,
  output logic             done_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= load_val_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  a_r9_load_only_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_q);

  a_r3_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0 && !load_i) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pwr_req_hold.sv
module pwr_req_hold #(
  parameter int unsigned PRED_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              irq_i,
  input  logic              wake_i,
  input  logic              req_i,
  input  logic              tgt_i,
  input  logic [PRED_W-1:0] pred_i,
  output logic              irq_o,
  output logic              wake_o,
  output logic              req_o,
  output logic              tgt_o,
  output logic [PRED_W-1:0] pred_o
);
  logic              irq_pq, wake_pq, req_pq, tgt_pq;
  logic [PRED_W-1:0] pred_pq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_pq  <= 1'b0;
      wake_pq <= 1'b0;
      req_pq  <= 1'b0;
      tgt_pq  <= 1'b0;
      pred_pq <= '0;
    end else if (busy_i) begin
      irq_pq  <= irq_pq | irq_i;
      wake_pq <= wake_pq | wake_i;
      if (req_i) begin
        req_pq  <= 1'b1;
        tgt_pq  <= tgt_i;
        pred_pq <= pred_i;
      end
    end else begin
      // held events are consumed or dropped on the first free cycle
      irq_pq  <= 1'b0;
      wake_pq <= 1'b0;
      req_pq  <= 1'b0;
    end
  end

  assign irq_o  = irq_i | irq_pq;
  assign wake_o = wake_i | wake_pq;
  assign req_o  = req_i | req_pq;
  assign tgt_o  = req_i ? tgt_i  : tgt_pq;
  assign pred_o = req_i ? pred_i : pred_pq;

  a_r9_held_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> (!irq_pq && !wake_pq && !req_pq));
endmodule

// File: rtl/pwr_break_even.sv
module pwr_break_even #(
  parameter int unsigned PRED_W      = 16,
  parameter int unsigned BE_IDLE_CYC = 40,
  parameter int unsigned BE_SLEEP_CYC = 600
) (
  input  logic              tgt_i,
  input  logic [PRED_W-1:0] pred_i,
  output logic              ok_o
);
  import pwr_state_pkg::*;
  localparam logic [PRED_W-1:0] THR_IDLE  = PRED_W'(BE_IDLE_CYC);
  localparam logic [PRED_W-1:0] THR_SLEEP = PRED_W'(BE_SLEEP_CYC);

  logic [PRED_W-1:0] thr;
  assign thr  = (tgt_i == TGT_SLEEP) ? THR_SLEEP : THR_IDLE;
  assign ok_o = pred_i > thr;
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int unsigned PRED_W        = 16,
  parameter int unsigned POW_W         = 20,
  parameter int unsigned LAT_RUN_IDLE  = 10,
  parameter int unsigned LAT_IDLE_RUN  = 10,
  parameter int unsigned LAT_TO_SLEEP  = 90,
  parameter int unsigned LAT_SLEEP_RUN = 4000,
  parameter int unsigned BE_IDLE_CYC   = 40,
  parameter int unsigned BE_SLEEP_CYC  = 600,
  parameter int unsigned P_RUN_UW      = 400000,
  parameter int unsigned P_IDLE_UW     = 50000,
  parameter int unsigned P_SLEEP_UW    = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lower_req_i,
  input  logic              lower_tgt_i,
  input  logic [PRED_W-1:0] pred_idle_i,
  input  logic              irq_i,
  input  logic              wake_i,
  output logic [1:0]        state_o,
  output logic              busy_o,
  output logic [POW_W-1:0]  power_uw_o
);
  localparam int unsigned LAT_M1 = (LAT_RUN_IDLE > LAT_IDLE_RUN) ? LAT_RUN_IDLE : LAT_IDLE_RUN;
  localparam int unsigned LAT_M2 = (LAT_TO_SLEEP > LAT_SLEEP_RUN) ? LAT_TO_SLEEP : LAT_SLEEP_RUN;
  localparam int unsigned LAT_MAX = (LAT_M1 > LAT_M2) ? LAT_M1 : LAT_M2;
  localparam int unsigned CNT_W = (LAT_MAX > 1) ? $clog2(LAT_MAX) : 1;

  localparam logic [CNT_W-1:0] LD_RUN_IDLE  = CNT_W'(LAT_RUN_IDLE - 1);
  localparam logic [CNT_W-1:0] LD_IDLE_RUN  = CNT_W'(LAT_IDLE_RUN - 1);
  localparam logic [CNT_W-1:0] LD_TO_SLEEP  = CNT_W'(LAT_TO_SLEEP - 1);
  localparam logic [CNT_W-1:0] LD_SLEEP_RUN = CNT_W'(LAT_SLEEP_RUN - 1);

  pstate_e           state_q, dst_q, dst_d;
  logic              busy, done, start;
  logic [CNT_W-1:0]  load_val;
  logic              e_irq, e_wake, e_req, e_tgt, be_ok;
  logic [PRED_W-1:0] e_pred;

  pwr_req_hold #(.PRED_W(PRED_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy),
    .irq_i  (irq_i),
    .wake_i (wake_i),
    .req_i  (lower_req_i),
    .tgt_i  (lower_tgt_i),
    .pred_i (pred_idle_i),
    .irq_o  (e_irq),
    .wake_o (e_wake),
    .req_o  (e_req),
    .tgt_o  (e_tgt),
    .pred_o (e_pred)
  );

  pwr_break_even #(
    .PRED_W(PRED_W), .BE_IDLE_CYC(BE_IDLE_CYC), .BE_SLEEP_CYC(BE_SLEEP_CYC)
  ) u_be (
    .tgt_i  (e_tgt),
    .pred_i (e_pred),
    .ok_o   (be_ok)
  );

  pwr_lat_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .load_val_i (load_val),
    .busy_o     (busy),
    .done_o     (done)
  );

  always_comb begin
    start    = 1'b0;
    dst_d    = state_q;
    load_val = '0;
    if (!busy) begin
      unique case (state_q)
        ST_RUN: begin
          if (e_req && be_ok && e_tgt == TGT_SLEEP) begin
            start = 1'b1; dst_d = ST_SLEEP; load_val = LD_TO_SLEEP;
          end else if (e_req && be_ok && e_tgt == TGT_IDLE) begin
            start = 1'b1; dst_d = ST_IDLE; load_val = LD_RUN_IDLE;
          end
        end
        ST_IDLE: begin
          if (e_irq) begin
            start = 1'b1; dst_d = ST_RUN; load_val = LD_IDLE_RUN;
          end else if (e_req && be_ok && e_tgt == TGT_SLEEP) begin
            start = 1'b1; dst_d = ST_SLEEP; load_val = LD_TO_SLEEP;
          end
        end
        ST_SLEEP: begin
          if (e_wake) begin
            start = 1'b1; dst_d = ST_RUN; load_val = LD_SLEEP_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      dst_q   <= ST_RUN;
    end else begin
      if (start) dst_q <= dst_d;
      if (done)  state_q <= dst_q;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE:  power_uw_o = POW_W'(P_IDLE_UW);
      ST_SLEEP: power_uw_o = POW_W'(P_SLEEP_UW);
      default:  power_uw_o = POW_W'(P_RUN_UW);
    endcase
  end

  assign state_o = state_q;
  assign busy_o  = busy;

  a_r9_state_stable_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(state_o));

  a_r7_sleep_exits_to_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SLEEP) |=> (state_o == ST_SLEEP || state_o == ST_RUN));

  a_r4_no_move_without_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && state_o == ST_RUN && !e_req) |=> !busy_o);

  a_r9_power_held_in_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done) |=> $stable(power_uw_o));
endmodule

// File: tb/pwr_state_ctrl_tb.sv
module pwr_state_ctrl_tb;
  localparam int LRI = 10, LIR = 10, LTS = 90, LSR = 4000;
  localparam int BEI = 40, BES = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, tgt = 1'b0, irq = 1'b0, wake = 1'b0;
  logic [15:0] pred = '0;
  logic [1:0]  state;
  logic        busy;
  logic [19:0] pow;

  int tests = 0, fails = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  pwr_state_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lower_req_i(req), .lower_tgt_i(tgt),
    .pred_idle_i(pred), .irq_i(irq), .wake_i(wake),
    .state_o(state), .busy_o(busy), .power_uw_o(pow)
  );

  // reference model: 0 run, 1 idle, 2 sleep
  int m_st = 0, m_busy = 0, m_rem = 0, m_dst = 0;
  int h_irq = 0, h_wake = 0, h_req = 0, h_tgt = 0, h_pred = 0;

  function automatic int pow_of(int s);
    if (s == 1) return 50000;
    if (s == 2) return 160;
    return 400000;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_busy = 0; m_rem = 0;
      h_irq = 0; h_wake = 0; h_req = 0;
    end else if (m_busy != 0) begin
      if (irq)  h_irq = 1;
      if (wake) h_wake = 1;
      if (req) begin h_req = 1; h_tgt = int'(tgt); h_pred = int'(pred); end
      if (m_rem == 1) begin m_st = m_dst; m_busy = 0; end
      else m_rem--;
    end else begin
      int ei, ew, er, et, ep, ok;
      ei = (irq || h_irq != 0) ? 1 : 0;
      ew = (wake || h_wake != 0) ? 1 : 0;
      er = (req || h_req != 0) ? 1 : 0;
      et = req ? int'(tgt) : h_tgt;
      ep = req ? int'(pred) : h_pred;
      ok = (et == 1) ? (ep > BES) : (ep > BEI);
      if (m_st == 0 && er != 0 && ok != 0) begin
        m_busy = 1; m_dst = (et == 1) ? 2 : 1; m_rem = (et == 1) ? LTS : LRI;
      end else if (m_st == 1 && ei != 0) begin
        m_busy = 1; m_dst = 0; m_rem = LIR;
      end else if (m_st == 1 && er != 0 && ok != 0 && et == 1) begin
        m_busy = 1; m_dst = 2; m_rem = LTS;
      end else if (m_st == 2 && ew != 0) begin
        m_busy = 1; m_dst = 0; m_rem = LSR;
      end
      h_irq = 0; h_wake = 0; h_req = 0;
    end
  end

  task automatic chk(input string t, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(tag, int'(state), m_st, "state");
    chk(tag, int'(busy), m_busy, "busy");
    chk("R2", int'(pow), pow_of(m_st), "power");
  end

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ask(input logic t, input int p);
    @(negedge clk); req = 1'b1; tgt = t; pred = 16'(p);
    @(negedge clk); req = 1'b0;
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq = 1'b1; @(negedge clk); irq = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(state), 0, "reset state");
    chk("R1", int'(busy), 0, "reset busy");
    chk("R1", int'(pow), 400000, "reset power");

    tag = "R8"; pulse_irq(); pulse_wake(); idle_cycles(3);
    chk("R8", int'(state), 0, "run after irq/wake");

    tag = "R4"; ask(1'b0, BEI); idle_cycles(3);
    chk("R4", int'(busy), 0, "idle at threshold");
    ask(1'b1, BES); idle_cycles(3);
    ask(1'b1, 500); idle_cycles(3);
    chk("R4", int'(state), 0, "sleep below threshold");

    tag = "R3"; ask(1'b0, BEI + 1); idle_cycles(LRI + 3);
    chk("R3", int'(state), 1, "landed idle");

    tag = "R6"; pulse_wake(); idle_cycles(3);
    chk("R6", int'(state), 1, "wake ignored in idle");
    pulse_irq(); idle_cycles(LIR + 3);
    chk("R6", int'(state), 0, "irq leaves idle");

    tag = "R3"; ask(1'b0, 100); idle_cycles(LRI + 3);
    tag = "R5"; ask(1'b1, BES + 1); idle_cycles(LTS + 3);
    chk("R5", int'(state), 2, "idle to sleep");

    tag = "R7"; pulse_irq(); ask(1'b1, 1000); idle_cycles(3);
    chk("R7", int'(state), 2, "irq ignored in sleep");
    pulse_wake(); idle_cycles(LSR + 3);
    chk("R7", int'(state), 0, "wake leaves sleep");

    tag = "R5"; ask(1'b1, 1000); idle_cycles(LTS + 3);
    chk("R5", int'(state), 2, "run to sleep");
    tag = "R7"; pulse_wake(); idle_cycles(LSR + 3);

    tag = "R9"; ask(1'b1, 1000); idle_cycles(20);
    pulse_wake(); idle_cycles(LTS);
    chk("R9", int'(busy), 1, "held wake restarts move");
    idle_cycles(LSR + 3);
    chk("R9", int'(state), 0, "back to run");

    ask(1'b0, 100); idle_cycles(3); pulse_irq(); idle_cycles(LRI + LIR + 3);
    chk("R9", int'(state), 0, "held irq returns to run");

    ask(1'b0, 100); idle_cycles(2); ask(1'b1, 700); idle_cycles(LRI + LTS + 3);
    chk("R9", int'(state), 2, "held request reaches sleep");
    pulse_wake(); idle_cycles(LSR + 3);

    tag = "R10"; ask(1'b0, 100); idle_cycles(LRI + 3);
    @(negedge clk); irq = 1'b1; req = 1'b1; tgt = 1'b1; pred = 16'd1000;
    @(negedge clk); irq = 1'b0; req = 1'b0;
    idle_cycles(LIR + 3);
    chk("R10", int'(state), 0, "irq wins over request");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule